// File: doc/BRIEF.md
# Pixel Stream Packing Writer

This block runs in the pixel clock domain. It watches a camera-style stream of 12-bit pixels and treats a pixel as valid only while both the frame qualifier and the line qualifier are high. Valid pixels are packed into 64-bit words for a memory write port. In the narrow mode each pixel is cut to its top eight bits, so eight pixels fill one word. In the wide mode each pixel is zero-extended to sixteen bits, so four pixels fill one word. Pixels fill a word from the least significant lane upward.

Capture is single-shot. A trigger arms the block, and the next complete frame is recorded, starting at a rising edge of the frame qualifier. The block counts data words into bursts of 32. For each burst it issues a write command, with an address that starts at a base input and grows by 256 bytes per burst. When the frame ends, any partly filled word is written out. A flush command then carries the words that did not fill a whole burst, and a frame-done pulse marks the end of the capture.

Top module: `pix_pack_writer`

## Requirements
- R1: While `rst_ni` is low, `wr_en_o`, `cmd_en_o` and `frame_done_o` are 0. After reset the block is idle: a frame that arrives without a trigger produces no write, no command and no done pulse.
- R2: During capture, only pixels sampled with both `fv_i` and `lv_i` high are packed. Cycles with `lv_i` low inside the frame add nothing.
- R3: When `mode_i`=0, bits 11:4 of each pixel are stored. Pixel k of a word goes to bits 8k+7:8k, with the first pixel in bits 7:0. A word is written (`wr_en_o` high for one cycle) on the clock edge that accepts its eighth pixel.
- R4: When `mode_i`=1, each pixel is stored as {4'b0, pixel}. Pixel k of a word goes to bits 16k+15:16k. A word is written on the edge that accepts its fourth pixel.
- R5: `mode_i` is sampled when capture starts. Changes to it during the frame have no effect on that frame.
- R6: `cmd_en_o` pulses in the cycle after the 32nd data word of a burst is written, with `cmd_words_o`=32. Burst k of a frame carries `cmd_addr_o` = base + 256·k.
- R7: At frame end, any partly filled word is written with its unused lanes zero. A flush command then carries the count of words that are still pending. If no words are pending, no command is issued.
- R8: A trigger arms the block. Capture begins only at the next rising edge of `fv_i`, so a frame already in progress when the trigger arrives is skipped. Triggers that arrive while the block is armed or capturing have no effect.
- R9: `frame_done_o` is a one-cycle pulse. It rises two clock edges after the first edge that samples `fv_i` low during capture, in the same cycle as any flush command.
- R10: `base_addr_i` is sampled when capture starts. Changes to it during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 12 | Pixel value |
| fv_i | input | 1 | Frame qualifier |
| lv_i | input | 1 | Line qualifier |
| trig_i | input | 1 | Arms a single-frame capture |
| mode_i | input | 1 | Packing mode: 0 = 8 bits per pixel, 1 = 16 bits per pixel |
| base_addr_i | input | 30 | Byte address of the first burst |
| wr_en_o | output | 1 | Write-data strobe |
| wr_data_o | output | 64 | Packed data word |
| cmd_en_o | output | 1 | Burst write command strobe |
| cmd_addr_o | output | 30 | Byte address of the burst |
| cmd_words_o | output | 6 | Number of data words in the burst |
| frame_done_o | output | 1 | Captured frame fully written |

## Verification
The bench targets frames whose pixel count is not a multiple of the word size, and frames whose word count is one more than a full burst. A design with a broken flush would lose the tail pixels or issue a command of length zero. A design that mishandled the burst boundary would repeat an address or leave out the one-word flush.

Other cases check that the start is taken from the edge of the frame qualifier rather than its level. These include a trigger that lands in the middle of a frame, an empty frame, and a reset during capture. A level-sensitive design would record a partial frame or fire a second capture. Mode and base-address changes in the middle of a frame would corrupt the packed data or the addresses of a design that failed to latch them.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAPT} cap_state_e;
  typedef enum logic {PACK_8B = 1'b0, PACK_16B = 1'b1} pack_mode_e;
endpackage

// File: rtl/pix_frame_ctrl.sv
module pix_frame_ctrl
  import pix_pack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fv_i,
  input  logic lv_i,
  input  logic trig_i,
  input  logic mode_i,
  output logic start_o,
  output logic pix_vld_o,
  output logic frame_end_o,
  output logic mode_o
);
  cap_state_e state_q;
  logic       fv_q;
  logic       mode_q;
  logic       fv_rise;

  assign fv_rise     = fv_i & ~fv_q;
  assign start_o     = (state_q == ST_ARMED) && fv_rise;
  assign frame_end_o = (state_q == ST_CAPT) && !fv_i;
  assign pix_vld_o   = lv_i && (start_o || ((state_q == ST_CAPT) && fv_i));
  assign mode_o      = start_o ? mode_i : mode_q;

  // fv_q resets high so a frame already running at reset release is not a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fv_q    <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      fv_q <= fv_i;
      unique case (state_q)
        ST_IDLE:  if (trig_i) state_q <= ST_ARMED;
        ST_ARMED: if (fv_rise) begin
          state_q <= ST_CAPT;
          mode_q  <= mode_i;
        end
        ST_CAPT:  if (!fv_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_capt_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAPT && $past(state_q) != ST_CAPT) |-> $past(fv_i && !fv_q && state_q == ST_ARMED));
endmodule

// File: rtl/pix_lane_packer.sv
module pix_lane_packer
  import pix_pack_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pix_vld_i,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              mode_i,
  input  logic              flush_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int LANES8  = WORD_W / 8;
  localparam int LANES16 = WORD_W / 16;
  localparam int LANE_W  = $clog2(LANES8);

  logic [LANE_W-1:0] lane_q, lane_cur;
  logic [WORD_W-1:0] acc_q, acc_cur, acc_nxt;
  logic              last;

  assign lane_cur = start_i ? '0 : lane_q;
  assign acc_cur  = start_i ? '0 : acc_q;

  always_comb begin
    acc_nxt = acc_cur;
    if (mode_i == PACK_16B) begin
      acc_nxt[lane_cur*16 +: 16] = {{(16-PIX_W){1'b0}}, pix_i};
      last = (lane_cur == LANE_W'(LANES16-1));
    end else begin
      acc_nxt[lane_cur*8 +: 8] = pix_i[PIX_W-1 -: 8];
      last = (lane_cur == LANE_W'(LANES8-1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q     <= '0;
      acc_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (pix_vld_i) begin
        if (last) begin
          word_vld_o <= 1'b1;
          word_o     <= acc_nxt;
          acc_q      <= '0;
          lane_q     <= '0;
        end else begin
          acc_q  <= acc_nxt;
          lane_q <= lane_cur + 1'b1;
        end
      end else if (flush_i) begin
        if (lane_q != '0) begin
          word_vld_o <= 1'b1;
          word_o     <= acc_q;
        end
        acc_q  <= '0;
        lane_q <= '0;
      end else if (start_i) begin
        acc_q  <= '0;
        lane_q <= '0;
      end
    end
  end

  assert_word_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(pix_vld_i || flush_i));
endmodule

// File: rtl/pix_burst_cmd.sv
module pix_burst_cmd #(
  parameter int WORD_W      = 64,
  parameter int BURST_WORDS = 32,
  parameter int ADDR_W      = 30,
  parameter int CNT_W       = $clog2(BURST_WORDS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              word_vld_i,
  input  logic              flush_i,
  output logic              cmd_en_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [CNT_W-1:0]  cmd_words_o
);
  localparam int BURST_BYTES = BURST_WORDS * WORD_W / 8;

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic              issue;

  assign cnt_nxt = cnt_q + CNT_W'(word_vld_i);
  assign issue   = (cnt_nxt == CNT_W'(BURST_WORDS)) || (flush_i && cnt_nxt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      addr_q      <= '0;
      cmd_en_o    <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_words_o <= '0;
    end else begin
      cmd_en_o <= 1'b0;
      if (start_i) begin
        cnt_q  <= '0;
        addr_q <= base_i;
      end else if (issue) begin
        cmd_en_o    <= 1'b1;
        cmd_addr_o  <= addr_q;
        cmd_words_o <= cnt_nxt;
        cnt_q       <= '0;
        addr_q      <= addr_q + ADDR_W'(BURST_BYTES);
      end else if (flush_i) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assert_full_burst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_en_o && !$past(flush_i)) |-> cmd_words_o == CNT_W'(BURST_WORDS));
  assert_cmd_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> (cmd_words_o != '0 && cmd_words_o <= CNT_W'(BURST_WORDS)));
endmodule

// File: rtl/pix_pack_writer.sv
module pix_pack_writer #(
  parameter int PIX_W       = 12,
  parameter int WORD_W      = 64,
  parameter int BURST_WORDS = 32,
  parameter int ADDR_W      = 30,
  localparam int CNT_W      = $clog2(BURST_WORDS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_i,
  input  logic              fv_i,
  input  logic              lv_i,
  input  logic              trig_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              wr_en_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              cmd_en_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [CNT_W-1:0]  cmd_words_o,
  output logic              frame_done_o
);
  logic start, pix_vld, frame_end, mode_eff, flush_d;

  pix_frame_ctrl u_ctrl (
    .clk_i, .rst_ni, .fv_i, .lv_i, .trig_i, .mode_i,
    .start_o(start), .pix_vld_o(pix_vld), .frame_end_o(frame_end), .mode_o(mode_eff)
  );

  pix_lane_packer #(.PIX_W(PIX_W), .WORD_W(WORD_W)) u_pack (
    .clk_i, .rst_ni, .start_i(start), .pix_vld_i(pix_vld), .pix_i, .mode_i(mode_eff),
    .flush_i(frame_end), .word_vld_o(wr_en_o), .word_o(wr_data_o)
  );

  // flush follows the last data word by one cycle so it is counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_d      <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      flush_d      <= frame_end;
      frame_done_o <= flush_d;
    end
  end

  pix_burst_cmd #(.WORD_W(WORD_W), .BURST_WORDS(BURST_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cmd (
    .clk_i, .rst_ni, .start_i(start), .base_i(base_addr_i), .word_vld_i(wr_en_o),
    .flush_i(flush_d), .cmd_en_o, .cmd_addr_o, .cmd_words_o
  );

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/pix_pack_writer_bench.sv
`timescale 1ns/1ps
module pix_pack_writer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] pix = '0;
  logic        fv = 1'b0, lv = 1'b0, trig = 1'b0, mode = 1'b0;
  logic [29:0] base = '0;
  logic        wr_en, cmd_en, done;
  logic [63:0] wr_data;
  logic [29:0] cmd_addr;
  logic [5:0]  cmd_words;

  always #2.5 clk = ~clk;

  pix_pack_writer u_pix_pack_writer (
    .clk_i(clk), .rst_ni, .pix_i(pix), .fv_i(fv), .lv_i(lv), .trig_i(trig), .mode_i(mode),
    .base_addr_i(base), .wr_en_o(wr_en), .wr_data_o(wr_data), .cmd_en_o(cmd_en),
    .cmd_addr_o(cmd_addr), .cmd_words_o(cmd_words), .frame_done_o(done)
  );

  int nchk = 0, nfail = 0, cyc = 0, seed = 1;
  logic [63:0] wlog [0:63];
  int          wcyc [0:63];
  logic [29:0] clog_a [0:7];
  int          clog_n [0:7];
  int          ccyc [0:7];
  int nw = 0, nc = 0, ndone = 0, done_cyc = 0, fall_cyc = 0;
  logic [11:0] px [0:1023];
  int npx = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (wr_en && nw < 64) begin wlog[nw] = wr_data; wcyc[nw] = cyc; nw++; end
    if (cmd_en && nc < 8) begin clog_a[nc] = cmd_addr; clog_n[nc] = cmd_words; ccyc[nc] = cyc; nc++; end
    if (done) begin ndone++; done_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic clear_logs(); nw = 0; nc = 0; ndone = 0; npx = 0; endtask

  task automatic pulse_trig(); trig = 1'b1; tick(); trig = 1'b0; endtask

  // flip_line: toggle mode and scramble base at that line; trig_line: pulse trigger there
  task automatic drive_frame(input int ppl, input int lines, input bit rec,
                             input int flip_line, input int trig_line);
    fv = 1'b1; tick();
    for (int l = 0; l < lines; l++) begin
      if (l == flip_line) begin mode = ~mode; base = 30'h3ABCDE0; end
      lv = 1'b1;
      for (int p = 0; p < ppl; p++) begin
        pix = 12'(seed * 131 + p * 37 + l * 7 + 11);
        if (rec) begin px[npx] = pix; npx++; end
        trig = (l == trig_line && p == 0);
        tick();
      end
      trig = 1'b0; lv = 1'b0; pix = '0;
      tick(); tick();
    end
    fv = 1'b0; fall_cyc = cyc;
    tick();
    seed++;
  endtask

  function automatic logic [63:0] exp_word(input int w, input bit m);
    logic [63:0] r = '0;
    int lanes = m ? 4 : 8;
    for (int j = 0; j < lanes; j++) begin
      int idx = w * lanes + j;
      if (idx < npx) begin
        if (m) r[16*j +: 16] = {4'b0, px[idx]};
        else   r[8*j +: 8]   = px[idx][11:4];
      end
    end
    return r;
  endfunction

  task automatic check_frame(input bit m, input logic [29:0] b, input int expw, input int expc);
    int lanes = m ? 4 : 8;
    string rq = m ? "R4" : "R3";
    chk(nw == expw, rq, "word count", 64'(nw), 64'(expw));
    chk(nw == (npx + lanes - 1) / lanes, "R2", "words vs valid pixels", 64'(nw), 64'((npx + lanes - 1) / lanes));
    for (int w = 0; w < nw && w < expw; w++)
      chk(wlog[w] == exp_word(w, m), rq, $sformatf("word %0d data", w), wlog[w], exp_word(w, m));
    chk(nc == expc, "R7", "command count", 64'(nc), 64'(expc));
    for (int k = 0; k < nc && k < expc; k++) begin
      int ew = (nw - 32 * k) > 32 ? 32 : nw - 32 * k;
      chk(clog_n[k] == ew, "R6", $sformatf("cmd %0d words", k), 64'(clog_n[k]), 64'(ew));
      chk(clog_a[k] == b + 30'(256 * k), "R10", $sformatf("cmd %0d addr", k), 64'(clog_a[k]), 64'(b + 30'(256 * k)));
      if (ew == 32)
        chk(ccyc[k] == wcyc[32 * k + 31] + 1, "R6", "burst cmd cycle", 64'(ccyc[k]), 64'(wcyc[32 * k + 31] + 1));
    end
    chk(ndone == 1, "R9", "done pulses", 64'(ndone), 64'd1);
    chk(done_cyc == fall_cyc + 2, "R9", "done cycle", 64'(done_cyc), 64'(fall_cyc + 2));
    if (nc > 0 && clog_n[nc-1] != 32)
      chk(ccyc[nc-1] == done_cyc, "R7", "flush cmd with done", 64'(ccyc[nc-1]), 64'(done_cyc));
  endtask

  localparam int NCASE = 6;
  localparam int C_MODE  [NCASE] = '{0, 1, 0, 1, 0, 1};
  localparam int C_PPL   [NCASE] = '{10, 10, 32, 33, 8, 50};
  localparam int C_LINES [NCASE] = '{4, 3, 8, 4, 1, 2};
  localparam int C_EXPW  [NCASE] = '{5, 8, 32, 33, 1, 25};
  localparam int C_EXPC  [NCASE] = '{1, 1, 1, 2, 1, 1};

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(!wr_en && !cmd_en && !done, "R1", "outputs in reset", {wr_en, cmd_en, done}, 64'd0);
    rst_ni = 1'b1; tick();

    // untriggered frame must be ignored
    clear_logs();
    drive_frame(16, 2, 1'b0, -1, -1);
    repeat (4) tick();
    chk(nw == 0 && ndone == 0, "R1", "no trigger no capture", 64'(nw + ndone), 64'd0);

    for (int i = 0; i < NCASE; i++) begin
      clear_logs();
      mode = C_MODE[i][0];
      base = 30'(32'h1000 * (i + 1));
      pulse_trig();
      drive_frame(C_PPL[i], C_LINES[i], 1'b1, -1, -1);
      repeat (4) tick();
      check_frame(C_MODE[i][0], 30'(32'h1000 * (i + 1)), C_EXPW[i], C_EXPC[i]);
    end

    // trigger inside a running frame: that frame is skipped, next is taken
    clear_logs();
    mode = 1'b0; base = 30'h20000;
    fv = 1'b1; tick(); lv = 1'b1; pix = 12'hFFF;
    pulse_trig();
    tick(); lv = 1'b0; fv = 1'b0; tick(); tick();
    chk(nw == 0 && ndone == 0, "R8", "partial frame skipped", 64'(nw + ndone), 64'd0);
    // trigger during capture has no effect
    drive_frame(12, 2, 1'b1, -1, 1);
    repeat (4) tick();
    check_frame(1'b0, 30'h20000, 3, 1);
    clear_logs();
    drive_frame(12, 2, 1'b0, -1, -1);
    repeat (4) tick();
    chk(nw == 0 && nc == 0 && ndone == 0, "R8", "retrigger ignored", 64'(nw + nc + ndone), 64'd0);

    // mode and base changes mid-frame are ignored
    clear_logs();
    mode = 1'b1; base = 30'h40000;
    pulse_trig();
    drive_frame(33, 4, 1'b1, 2, -1);
    repeat (4) tick();
    check_frame(1'b1, 30'h40000, 33, 2);
    chk(mode == 1'b0, "R5", "mode input was flipped", 64'(mode), 64'd0);

    // empty frame: done without command
    clear_logs();
    pulse_trig();
    fv = 1'b1; tick(); tick(); tick(); fv = 1'b0; fall_cyc = cyc; tick();
    repeat (4) tick();
    chk(nc == 0 && nw == 0, "R7", "empty frame no cmd", 64'(nc + nw), 64'd0);
    chk(ndone == 1 && done_cyc == fall_cyc + 2, "R9", "empty frame done", 64'(ndone), 64'd1);

    // reset during capture returns to idle
    clear_logs();
    pulse_trig();
    fv = 1'b1; tick(); lv = 1'b1;
    for (int p = 0; p < 5; p++) begin pix = 12'(p); tick(); end
    rst_ni = 1'b0; #1;
    chk(!wr_en && !cmd_en && !done, "R1", "outputs on reset", {wr_en, cmd_en, done}, 64'd0);
    tick(); rst_ni = 1'b1; clear_logs();
    for (int p = 0; p < 10; p++) begin pix = 12'(p); tick(); end
    lv = 1'b0; fv = 1'b0; tick();
    repeat (4) tick();
    chk(nw == 0 && nc == 0 && ndone == 0, "R1", "idle after reset", 64'(nw + nc + ndone), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule